// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit little-endian data memory and a processor register file. On a load it picks the byte or halfword addressed by the low address bits and widens it to 32 bits, with zeros or with copies of its sign bit. On a store it copies the register's low byte or low halfword into every lane of the write bus and raises only the byte strobes of the lanes addressed.

A halfword at an odd address, and a word store that is not word aligned, are refused: the block raises an error and starts no memory cycle. A word load that is not word aligned is split by a small sequencer into two reads. The first read is of the aligned word that holds the lowest byte and the second is of the next word. The first word is kept in a register and the two are merged into one result. The memory has a one-cycle read latency, so read data returns in the cycle after the request.

Top module: `lsu_lane_aligner`

## Requirements
- R1: A word load at an address whose two lowest bits are zero returns the four bytes in little-endian order. Bytes 0x56, 0x23, 0x0D, 0xAE at ascending addresses give 0xAE0D2356.
- R2: Size code 0 is a byte and code 1 is a halfword. An unsigned byte or halfword load returns the addressed lane, with address bits 1:0 selecting the byte and bit 1 selecting the halfword, and fills the upper bits with zeros.
- R3: A signed byte load copies bit 7 of the byte into bits 31:8. A signed halfword load copies bit 15 into bits 31:16, so 0x8204 gives 0xFFFF8204.
- R4: On a store, a byte store repeats bits 7:0 of the store data in all four lanes and a halfword store repeats bits 15:0 in both halves. Only the addressed lanes of memory change.
- R5: Store byte enables use bit n for byte lane n. A byte store sets exactly one bit, at the address offset. A halfword store sets 0011 when address bit 1 is 0 and 1100 when it is 1. A word store (size code 2) sets 1111.
- R6: A halfword access at an odd address, or a word store whose address is not word aligned, raises the misalignment error in the request cycle. It drives no memory enable and produces no load result.
- R7: A word load with nonzero address bits 1:0 reads the aligned word containing the first byte and then the following word, one cycle apart. It returns the four bytes from the address upward in little-endian order.
- R8: A split load holds busy high for two cycles after the request cycle. Requests presented while busy is high are ignored and start no memory cycle.
- R9: The load result is flagged valid exactly one cycle after an aligned load request, and two cycles after the request for a split load.
- R10: After reset, busy and the load-valid flag are low, and no memory cycle starts without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Access request present |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend the load result |
| req_addr | input | AW | Byte address of the access |
| st_data | input | 32 | Register value to store |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane write strobes |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended or merged load result |
| misalign_err | output | 1 | Refused misaligned access |
| busy | output | 1 | Split load in progress |

## Verification
The bench builds the block with an 8-bit address (AW = 8) and a 16-word model memory. Misaligned loads can then cross several word boundaries, including one at the top of the preloaded region, with no long address constants. Its table covers every byte and halfword lane in both extension modes. Directed sequences cover the split loads, a store attempted during a split, the refused accesses, and store read-back that shows which lanes changed.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SECOND = 2'd1,
    SQ_FINISH = 2'd2
  } split_st_e;
endpackage

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
(
  input  logic [1:0]      size_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [DW-1:0]   data_i,
  output logic [LANES-1:0] be_o,
  output logic [DW-1:0]   wdata_o
);
  logic is_word;
  logic is_half;
  assign is_word = size_i[1];
  assign is_half = (size_i == SZ_HALF);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (is_word) begin
        be_o[g]            = 1'b1;
        wdata_o[8*g +: 8]  = data_i[8*g +: 8];
      end else if (is_half) begin
        be_o[g]            = ((g / 2) == int'(off_i[1]));
        wdata_o[8*g +: 8]  = data_i[8*(g % 2) +: 8];
      end else begin
        be_o[g]            = (int'(off_i) == g);
        wdata_o[8*g +: 8]  = data_i[7:0];
      end
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
(
  input  logic [DW-1:0]   rdata_i,
  input  logic [DW-1:0]   hold_i,
  input  logic            merge_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [1:0]      size_i,
  input  logic            sgn_i,
  output logic [DW-1:0]   data_o
);
  logic [2*DW-1:0] pair;
  logic [DW-1:0]   merged;
  logic [DW-1:0]   lane;
  logic [OFFW+2:0] sh;

  always_comb begin
    sh     = {off_i, 3'b000};
    pair   = {rdata_i, hold_i};
    merged = DW'(pair >> sh);
    lane   = rdata_i >> sh;
    if (merge_i) begin
      data_o = merged;
    end else if (size_i[1]) begin
      data_o = rdata_i;
    end else if (size_i == SZ_HALF) begin
      data_o = {{(DW-16){sgn_i & lane[15]}}, lane[15:0]};
    end else begin
      data_o = {{(DW-8){sgn_i & lane[7]}}, lane[7:0]};
    end
  end
endmodule

// File: rtl/lsu_split_seq.sv
module lsu_split_seq
  import lsu_lane_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic          second_o,
  output logic          finish_o,
  output logic [DW-1:0] hold_o
);
  split_st_e st_q, st_d;
  logic      hold_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE:   if (start_i) st_d = SQ_SECOND;
      SQ_SECOND: st_d = SQ_FINISH;
      default:   st_d = SQ_IDLE;
    endcase
  end

  assign hold_en  = (st_q == SQ_SECOND);
  assign busy_o   = (st_q != SQ_IDLE);
  assign second_o = (st_q == SQ_SECOND);
  assign finish_o = (st_q == SQ_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_o <= '0;
    else if (hold_en) hold_o <= rdata_i;
  end

  // R8: the split sequence spans exactly two cycles
  a_r8_second_then_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_SECOND) |=> (st_q == SQ_FINISH));
  a_r8_finish_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FINISH) |=> (st_q == SQ_IDLE));
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
  import lsu_lane_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   st_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          ld_valid,
  output logic [31:0]   ld_data,
  output logic          misalign_err,
  output logic          busy
);
  localparam logic [AW-1:0] WSTEP = AW'(LANES);

  logic            accept, mis_half, mis_word, go, split, ld_pend_d;
  logic            seq_second, seq_finish;
  logic [DW-1:0]   hold;
  logic [LANES-1:0] st_be;
  logic [DW-1:0]   st_wdata;
  logic [AW-1:0]   base_addr;

  logic [AW-1:0]   addr_q;
  logic [OFFW-1:0] off_q;
  logic [1:0]      size_q;
  logic            sgn_q;
  logic            ld_pend_q;

  // request decode
  always_comb begin
    accept       = req_valid && !busy;
    mis_half     = (req_size == SZ_HALF) && req_addr[0];
    mis_word     = req_size[1] && (req_addr[OFFW-1:0] != '0);
    misalign_err = accept && (mis_half || (mis_word && req_store));
    go           = accept && !misalign_err;
    split        = go && !req_store && mis_word;
    ld_pend_d    = go && !req_store && !mis_word;
    base_addr    = {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
  end

  // memory side
  always_comb begin
    mem_en    = go || seq_second;
    mem_we    = go && req_store;
    mem_addr  = seq_second ? (addr_q + WSTEP) : base_addr;
    mem_be    = mem_we ? st_be : '1;
    mem_wdata = st_wdata;
  end

  lsu_store_lanes u_st (
    .size_i (req_size),
    .off_i  (req_addr[OFFW-1:0]),
    .data_i (st_data),
    .be_o   (st_be),
    .wdata_o(st_wdata)
  );

  lsu_split_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (split),
    .rdata_i (mem_rdata),
    .busy_o  (busy),
    .second_o(seq_second),
    .finish_o(seq_finish),
    .hold_o  (hold)
  );

  // request attributes, loaded under clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      off_q  <= '0;
      size_q <= '0;
      sgn_q  <= 1'b0;
    end else if (go) begin
      addr_q <= base_addr;
      off_q  <= req_addr[OFFW-1:0];
      size_q <= req_size;
      sgn_q  <= req_signed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_pend_q <= 1'b0;
    else        ld_pend_q <= ld_pend_d;
  end

  lsu_load_extract u_ld (
    .rdata_i(mem_rdata),
    .hold_i (hold),
    .merge_i(seq_finish),
    .off_i  (off_q),
    .size_i (size_q),
    .sgn_i  (sgn_q),
    .data_o (ld_data)
  );

  assign ld_valid = ld_pend_q || seq_finish;

  // R6: a refused access starts no memory cycle
  a_r6_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> !mem_en);
  // R5: write strobes are one, two or four lanes
  a_r5_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                            mem_be == 4'b1100 || mem_be == 4'b1111));
  // R9: every load result follows a read one cycle earlier
  a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_en && !mem_we));
  // R7: the second read of a split is the next word
  a_r7_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    seq_second |-> (mem_addr == $past(mem_addr) + WSTEP));
  // R8: no write can start while busy
  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);
endmodule

// File: tb/sim_lsu_lane_aligner.sv
`timescale 1ns/1ps
module sim_lsu_lane_aligner;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_store, req_signed;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   st_data;
  logic          mem_en, mem_we, ld_valid, misalign_err, busy;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata, ld_data;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] mem [16];

  always #2.5 clk = ~clk;

  lsu_lane_aligner #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .st_data(st_data), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .misalign_err(misalign_err),
    .busy(busy)
  );

  // model memory with one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
      mem[0] <= 32'hAE0D2356;
      mem[1] <= 32'hCDEF8204;
      mem[2] <= 32'h7F80FF01;
      mem[3] <= 32'h12345678;
      mem[4] <= 32'h9ABCDEF0;
      mem_rdata <= 32'h0;
    end else if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic sg,
                       input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    req_addr = a; st_data = d;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  task automatic aligned_load(input string req, input logic [1:0] sz, input logic sg,
                              input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk); drive(1'b0, sz, sg, a, 32'h0);
    @(negedge clk); idle();
    chk(req, {31'h0, ld_valid}, 32'h1);
    chk(req, ld_data, exp);
  endtask

  task automatic split_load(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk); drive(1'b0, 2'd2, 1'b0, a, 32'h0);
    @(negedge clk); idle();
    chk({req, " busy"}, {31'h0, busy}, 32'h1);
    chk({req, " early valid"}, {31'h0, ld_valid}, 32'h0);
    @(negedge clk);
    chk({req, " valid"}, {31'h0, ld_valid}, 32'h1);
    chk(req, ld_data, exp);
  endtask

  // table: {size, signed, addr, expected}
  localparam int NT = 13;
  localparam logic [42:0] TBL [NT] = '{
    {2'd2, 1'b0, 8'd0,  32'hAE0D2356},
    {2'd2, 1'b0, 8'd4,  32'hCDEF8204},
    {2'd0, 1'b0, 8'd0,  32'h00000056},
    {2'd0, 1'b1, 8'd3,  32'hFFFFFFAE},
    {2'd0, 1'b1, 8'd5,  32'hFFFFFF82},
    {2'd0, 1'b0, 8'd5,  32'h00000082},
    {2'd0, 1'b1, 8'd9,  32'hFFFFFFFF},
    {2'd0, 1'b1, 8'd11, 32'h0000007F},
    {2'd1, 1'b0, 8'd0,  32'h00002356},
    {2'd1, 1'b1, 8'd4,  32'hFFFF8204},
    {2'd1, 1'b0, 8'd4,  32'h00008204},
    {2'd1, 1'b0, 8'd6,  32'h0000CDEF},
    {2'd1, 1'b1, 8'd10, 32'h00007F80}
  };

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle(); req_size = 2'd0; req_signed = 1'b0; req_addr = '0; st_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", {31'h0, busy}, 32'h0);
    chk("R10 ld_valid", {31'h0, ld_valid}, 32'h0);
    chk("R10 mem_en", {31'h0, mem_en}, 32'h0);

    // R1 R2 R3 R9 table walk
    for (int i = 0; i < NT; i++)
      aligned_load("R1/R2/R3/R9 table", TBL[i][42:41], TBL[i][40], TBL[i][39:32], TBL[i][31:0]);

    // R7 split loads
    split_load("R7 addr1", 8'd1, 32'h04AE0D23);
    split_load("R7 addr14", 8'd14, 32'hDEF01234);

    // R8 store attempted while busy is ignored
    @(negedge clk); drive(1'b0, 2'd2, 1'b0, 8'd3, 32'h0);
    #1 chk("R7 first read addr", {24'h0, mem_addr}, 32'h0);
    @(negedge clk); drive(1'b1, 2'd0, 1'b0, 8'd0, 32'h000000EE);
    #1;
    chk("R8 busy", {31'h0, busy}, 32'h1);
    chk("R8 no write while busy", {31'h0, mem_we}, 32'h0);
    chk("R7 second read addr", {24'h0, mem_addr}, 32'h4);
    @(negedge clk);
    chk("R8 busy second cycle", {31'h0, busy}, 32'h1);
    chk("R9 split valid", {31'h0, ld_valid}, 32'h1);
    chk("R7 addr3", ld_data, 32'hEF8204AE);
    idle();
    @(negedge clk);
    chk("R8 busy drops", {31'h0, busy}, 32'h0);
    chk("R9 no extra valid", {31'h0, ld_valid}, 32'h0);
    aligned_load("R8 ignored store left memory", 2'd0, 1'b0, 8'd0, 32'h00000056);

    // R6 refused accesses
    @(negedge clk); drive(1'b0, 2'd1, 1'b0, 8'd1, 32'h0);
    #1;
    chk("R6 half odd err", {31'h0, misalign_err}, 32'h1);
    chk("R6 half odd no access", {31'h0, mem_en}, 32'h0);
    @(negedge clk); idle();
    chk("R6 no result", {31'h0, ld_valid}, 32'h0);
    @(negedge clk); drive(1'b1, 2'd2, 1'b0, 8'd2, 32'h11111111);
    #1;
    chk("R6 word store err", {31'h0, misalign_err}, 32'h1);
    chk("R6 word store no access", {31'h0, mem_en}, 32'h0);
    @(negedge clk); drive(1'b1, 2'd1, 1'b0, 8'd3, 32'h22222222);
    #1 chk("R6 half store odd", {31'h0, misalign_err}, 32'h1);
    @(negedge clk); drive(1'b0, 2'd0, 1'b0, 8'd1, 32'h0);
    #1 chk("R6 byte never misaligned", {31'h0, misalign_err}, 32'h0);
    @(negedge clk); idle();
    aligned_load("R4 refused store left word 0", 2'd2, 1'b0, 8'd0, 32'hAE0D2356);

    // R4 R5 stores
    @(negedge clk); drive(1'b1, 2'd0, 1'b0, 8'd6, 32'h123456AB);
    #1;
    chk("R5 byte be", {28'h0, mem_be}, 32'h4);
    chk("R4 byte wdata", mem_wdata, 32'hABABABAB);
    chk("R5 byte we", {31'h0, mem_we}, 32'h1);
    @(negedge clk); drive(1'b1, 2'd1, 1'b0, 8'd2, 32'hFFFF5AA5);
    #1;
    chk("R5 half be upper", {28'h0, mem_be}, 32'hC);
    chk("R4 half wdata", mem_wdata, 32'h5AA55AA5);
    @(negedge clk); drive(1'b1, 2'd1, 1'b0, 8'd8, 32'h0000BEEF);
    #1 chk("R5 half be lower", {28'h0, mem_be}, 32'h3);
    @(negedge clk); drive(1'b1, 2'd2, 1'b0, 8'd12, 32'hCAFEF00D);
    #1;
    chk("R5 word be", {28'h0, mem_be}, 32'hF);
    chk("R4 word wdata", mem_wdata, 32'hCAFEF00D);
    @(negedge clk); drive(1'b1, 2'd0, 1'b0, 8'd1, 32'h00000099);
    #1 chk("R5 byte be lane1", {28'h0, mem_be}, 32'h2);
    @(negedge clk); idle();
    aligned_load("R4 readback word1", 2'd2, 1'b0, 8'd4, 32'hCDAB8204);
    aligned_load("R4 readback word0", 2'd2, 1'b0, 8'd0, 32'h5AA59956);
    aligned_load("R4 readback word2", 2'd2, 1'b0, 8'd8, 32'h7F80BEEF);
    aligned_load("R4 readback word3", 2'd2, 1'b0, 8'd12, 32'hCAFEF00D);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule